// File: doc/BRIEF.md
# AC-link Frame Sync and Transmit Serializer

This block is the controller end of the outgoing half of an AC-link audio codec interface. It runs on the serial bit clock that the codec drives, 12.288 MHz in a standard system, and divides it into frames of 256 bits, giving a 48 kHz frame rate. The frame sync line is high for the first 16 bits of every frame, which form the tag phase. The other 240 bits form the data phase and hold twelve slots of 20 bits each. Every output changes on the rising bit-clock edge, so the codec can sample it on the falling edge.

Software places the next frame's twelve slot words and twelve slot-valid flags on a parallel load port. The block builds the tag from the flags. A one-cycle frame request strobe during the last bit of each frame marks the rising edge at which the port is captured. A shut-off input quiets the link: sync, serial data and the request strobe all drop to a steady low level. When shut-off is released, a fresh frame starts at the next edge.

Top module: `aclnk_tx_core`

## Requirements
- R1: While reset is active, sync, sdout and frame_req are low. The first rising edge after reset is released (with shutoff low) captures the load port and starts a frame, so sync is high in the cycle that follows.
- R2: When shutoff stays low, frames repeat every 256 bit clocks, so frame_req pulses exactly 256 cycles apart.
- R3: sync is high for exactly the first 16 bit times of every frame and low for the remaining 240.
- R4: The tag is sent most significant bit first in bit times 0 to 15. Tag bit 15 (bit time 0) is the OR of all twelve slot_valid flags. Tag bit 14-i (bit time 1+i) carries slot_valid[i], which is the flag for slot i+1.
- R5: Slot n (1 to 12) takes its word from slot_data[(n-1)*20 +: 20]. The slots are sent in order 1 to 12, each most significant bit first, starting at bit time 16 + 20*(n-1).
- R6: Tag bits 2, 1 and 0 (bit times 13 to 15) are always sent as 0.
- R7: When shutoff is high at a rising edge, sync, sdout and frame_req are low from that edge on and stay low while it remains high. The first edge with shutoff low then captures the load port and starts a new frame from bit time 0.
- R8: frame_req is high only during bit time 255 of a running frame, for one cycle.
- R9: The load port is sampled only at the rising edge that ends bit time 255 (or the first edge after reset or shut-off). Changes to it at any other time do not alter the frame on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock from the codec; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| shutoff | input | 1 | High holds the link quiet and low |
| slot_valid | input | 12 | Valid flag for each slot; bit i belongs to slot i+1 |
| slot_data | input | 240 | Slot words; slot n occupies bits (n-1)*20 +: 20 |
| sync | output | 1 | Frame sync, high during the 16-bit tag phase |
| sdout | output | 1 | Serial frame data, most significant bit first |
| frame_req | output | 1 | High during the last bit of a frame; the port is captured at the edge ending it |

## Verification
Every output comes from registers, so each output reflects the input values sampled at the preceding rising edge. The load port captured at the edge ending frame_req shows up as tag bit 15 in the very next cycle. A shut-off sampled at an edge silences the outputs in the cycle after that edge, and releasing it brings sync high one cycle after the first edge with shutoff low. The bench drives inputs on falling edges. A behavioural model advances at each rising edge and compares all three outputs at the next falling edge, so each comparison sees exactly one edge's worth of change. The bench also perturbs the load port mid-frame and applies shut-off during both the tag phase and the data phase.

// File: rtl/aclnk_pkg.sv
`timescale 1ns/1ps
package aclnk_pkg;
  localparam int DEF_TAG_W   = 16;
  localparam int DEF_SLOT_W  = 20;
  localparam int DEF_N_SLOTS = 12;

  // Bits in one frame: tag phase plus all slots
  function automatic int frame_bits(input int tag_w, input int slot_w, input int n_slots);
    return tag_w + n_slots * slot_w;
  endfunction

  // Start bit time of a slot counted from 0 (slot 0 is the first slot)
  function automatic int slot_start(input int tag_w, input int slot_w, input int idx);
    return tag_w + idx * slot_w;
  endfunction
endpackage

// File: rtl/aclnk_frame_timer.sv
`timescale 1ns/1ps
module aclnk_frame_timer #(
  parameter int FRAME_W = 256,
  parameter int TAG_W   = 16,
  localparam int POS_W  = $clog2(FRAME_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shutoff,
  output logic quiet,
  output logic last_bit,
  output logic in_tag,
  output logic load_now
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_W - 1);

  logic [POS_W-1:0] pos;

  function automatic logic tag_phase(input logic [POS_W-1:0] p);
    return int'(p) < TAG_W;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= LAST;
      quiet <= 1'b1;
    end else if (shutoff) begin
      pos   <= LAST;
      quiet <= 1'b1;
    end else begin
      quiet <= 1'b0;
      pos   <= (pos == LAST) ? '0 : pos + 1'b1;
    end
  end

  assign last_bit = (pos == LAST);
  assign in_tag   = tag_phase(pos);
  assign load_now = last_bit && !shutoff;
endmodule

// File: rtl/aclnk_frame_shifter.sv
`timescale 1ns/1ps
module aclnk_frame_shifter #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  localparam int FRAME_W = aclnk_pkg::frame_bits(TAG_W, SLOT_W, N_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      hold,
  input  logic [N_SLOTS-1:0]        slot_valid,
  input  logic [N_SLOTS*SLOT_W-1:0] slot_data,
  output logic                      msb
);
  logic [FRAME_W-1:0] image;
  logic [FRAME_W-1:0] shreg;

  // Tag: top bit flags a valid frame, then one flag per slot, rest zero
  function automatic logic [TAG_W-1:0] make_tag(input logic [N_SLOTS-1:0] v);
    logic [TAG_W-1:0] t;
    t = '0;
    t[TAG_W-1] = |v;
    for (int i = 0; i < N_SLOTS; i++) t[TAG_W-2-i] = v[i];
    return t;
  endfunction

  assign image[FRAME_W-1 -: TAG_W] = make_tag(slot_valid);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    localparam int TOP = FRAME_W - 1 - aclnk_pkg::slot_start(TAG_W, SLOT_W, s);
    assign image[TOP -: SLOT_W] = slot_data[s*SLOT_W +: SLOT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= image;
    else if (!hold) shreg <= {shreg[FRAME_W-2:0], 1'b0};
  end

  assign msb = shreg[FRAME_W-1];
endmodule

// File: rtl/aclnk_tx_core.sv
`timescale 1ns/1ps
module aclnk_tx_core #(
  parameter int TAG_W   = aclnk_pkg::DEF_TAG_W,
  parameter int SLOT_W  = aclnk_pkg::DEF_SLOT_W,
  parameter int N_SLOTS = aclnk_pkg::DEF_N_SLOTS,
  localparam int FRAME_W = aclnk_pkg::frame_bits(TAG_W, SLOT_W, N_SLOTS)
) (
  input  logic                      bclk,
  input  logic                      rst_n,
  input  logic                      shutoff,
  input  logic [N_SLOTS-1:0]        slot_valid,
  input  logic [N_SLOTS*SLOT_W-1:0] slot_data,
  output logic                      sync,
  output logic                      sdout,
  output logic                      frame_req
);
  logic quiet;
  logic last_bit;
  logic in_tag;
  logic load_now;
  logic line_bit;

  aclnk_frame_timer #(.FRAME_W(FRAME_W), .TAG_W(TAG_W)) u_timer (
    .clk      (bclk),
    .rst_n    (rst_n),
    .shutoff  (shutoff),
    .quiet    (quiet),
    .last_bit (last_bit),
    .in_tag   (in_tag),
    .load_now (load_now)
  );

  aclnk_frame_shifter #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)) u_shift (
    .clk        (bclk),
    .rst_n      (rst_n),
    .load       (load_now),
    .hold       (shutoff),
    .slot_valid (slot_valid),
    .slot_data  (slot_data),
    .msb        (line_bit)
  );

  assign sync      = in_tag && !quiet;
  assign sdout     = line_bit && !quiet;
  assign frame_req = last_bit && !quiet;
endmodule

// File: rtl/aclnk_tx_chk.sv
`timescale 1ns/1ps
module aclnk_tx_chk #(
  parameter int TAG_W   = 16,
  parameter int N_SLOTS = 12,
  parameter int FRAME_W = 256
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shutoff,
  input logic [N_SLOTS-1:0] slot_valid,
  input logic               sync,
  input logic               sdout,
  input logic               frame_req
);
  logic [15:0] gap;
  logic        clean;
  logic [15:0] sync_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '0;
      clean    <= 1'b0;
      sync_run <= '0;
    end else begin
      gap      <= frame_req ? 16'd0 : gap + 16'd1;
      clean    <= shutoff ? 1'b0 : (frame_req ? 1'b1 : clean);
      sync_run <= sync ? sync_run + 16'd1 : 16'd0;
    end
  end

  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_req && clean) |-> (gap == 16'(FRAME_W - 1))); // R2
  AST_SYNC_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync) && !$past(shutoff)) |-> (sync_run == 16'(TAG_W))); // R3
  AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && sync_run == 16'd0) |-> (sdout == |$past(slot_valid))); // R4
  AST_TAG_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && sync_run >= 16'(N_SLOTS + 1)) |-> !sdout); // R6
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    shutoff |=> (!sync && !sdout && !frame_req)); // R7
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req |=> !frame_req); // R8
  AST_REQ_STARTS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_req && !shutoff) |=> sync); // R8
endmodule

bind aclnk_tx_core aclnk_tx_chk #(.TAG_W(TAG_W), .N_SLOTS(N_SLOTS), .FRAME_W(FRAME_W)) u_chk (
  .clk        (bclk),
  .rst_n      (rst_n),
  .shutoff    (shutoff),
  .slot_valid (slot_valid),
  .sync       (sync),
  .sdout      (sdout),
  .frame_req  (frame_req)
);

// File: tb/aclnk_tx_core_test.sv
`timescale 1ns/1ps
module aclnk_tx_core_test;
  localparam int NS = 12;
  localparam int SW = 20;
  localparam int FB = 256;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           shutoff = 1'b0;
  logic [NS-1:0]  slot_valid = '0;
  logic [NS*SW-1:0] slot_data = '0;
  logic           sync, sdout, frame_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit running = 1'b0;
  bit scr_frame = 1'b0;

  always #2.5 clk = ~clk;

  aclnk_tx_core uut (
    .bclk(clk), .rst_n(rst_n), .shutoff(shutoff), .slot_valid(slot_valid),
    .slot_data(slot_data), .sync(sync), .sdout(sdout), .frame_req(frame_req)
  );

  // Index 0 is the first bit on the line
  function automatic logic [FB-1:0] ref_frame(input logic [NS-1:0] v, input logic [NS*SW-1:0] d);
    logic [FB-1:0] f;
    f = '0;
    f[0] = |v;
    for (int i = 0; i < NS; i++) f[1+i] = v[i];
    for (int s = 0; s < NS; s++)
      for (int j = 0; j < SW; j++) f[16 + SW*s + j] = d[s*SW + SW-1-j];
    return f;
  endfunction

  bit            m_off;
  int            m_pos;
  logic [FB-1:0] m_frame;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_off <= 1'b1; m_pos <= FB-1;
    end else if (shutoff) begin
      m_off <= 1'b1; m_pos <= FB-1;
    end else begin
      m_off <= 1'b0;
      if (m_pos == FB-1) begin
        m_pos   <= 0;
        m_frame <= ref_frame(slot_valid, slot_data);
      end else m_pos <= m_pos + 1;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      logic e_sync, e_sd, e_req;
      string tg;
      e_sync = !m_off && (m_pos < 16);
      e_sd   = !m_off && m_frame[m_pos];
      e_req  = !m_off && (m_pos == FB-1);
      if (m_off) tg = "R7";
      else if (m_pos < 13) tg = "R4";
      else if (m_pos < 16) tg = "R6";
      else if (scr_frame) tg = "R9";
      else tg = "R5";
      check(m_off ? "R7" : "R3", "sync", sync, e_sync);
      check(tg, "sdout", sdout, e_sd);
      check(m_off ? "R7" : "R8", "frame_req", frame_req, e_req);
    end
  end

  // R2: spacing between request pulses on uninterrupted frames
  int cyc = 0;
  int last_req = -1;
  bit shut_seen = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (shutoff) shut_seen = 1'b1;
    if (running && rst_n && frame_req) begin
      if (last_req >= 0 && !shut_seen) check("R2", "request spacing", (cyc - last_req) == FB, 1'b1);
      last_req = cyc;
      shut_seen = 1'b0;
    end
  end

  task automatic fill_data(input int seed);
    for (int s = 0; s < NS; s++) slot_data[s*SW +: SW] = 20'($urandom) ^ 20'(seed);
  endtask

  task automatic next_frame(input logic [NS-1:0] v, input int seed);
    do @(negedge clk); while (!frame_req);
    scr_frame = 1'b0;
    slot_valid = v;
    fill_data(seed);
  endtask

  initial begin
    slot_valid = 12'hFFF;
    fill_data(1);
    repeat (3) @(negedge clk);
    check("R1", "sync in reset", sync, 1'b0);
    check("R1", "sdout in reset", sdout, 1'b0);
    check("R1", "frame_req in reset", frame_req, 1'b0);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);
    check("R1", "sync after first edge", sync, 1'b1);
    check("R4", "frame flag all valid", sdout, 1'b1);
    next_frame(12'h000, 2);
    next_frame(12'h001, 3);
    next_frame(12'h800, 4);
    next_frame(12'hA5A, 5);
    // R9: perturb the load port mid-frame
    repeat (20) @(negedge clk);
    scr_frame = 1'b1;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      slot_valid = 12'($urandom);
      fill_data(k);
    end
    next_frame(12'h3C3, 6);
    // R7: shut off in the data phase
    repeat (60) @(negedge clk);
    shutoff = 1'b1;
    repeat (30) @(negedge clk);
    check("R7", "quiet sync", sync, 1'b0);
    check("R7", "quiet sdout", sdout, 1'b0);
    shutoff = 1'b0;
    slot_valid = 12'h0F0;
    fill_data(7);
    @(negedge clk);
    check("R7", "sync on resume", sync, 1'b1);
    next_frame(12'hFFF, 8);
    // R7: shut off during the tag phase
    repeat (5) @(negedge clk);
    shutoff = 1'b1;
    repeat (3) @(negedge clk);
    shutoff = 1'b0;
    next_frame(12'h555, 9);
    next_frame(12'hAAA, 10);
    next_frame(12'h000, 11);
    repeat (FB + 10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule